// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog timer for a large chip. It has an 8-bit up-counter that advances on ticks from a power-of-two prescaler. Software has to restart the counter before it wraps. If the counter wraps from its top value to zero, the block does one of two things, depending on the selected mode:

- In watchdog mode it sends a one-cycle reset request to the reset controller. A control bit chooses whether the request is for a power-on reset or a manual reset.
- In interval mode it sets a sticky flag and raises an interrupt.

Stray writes cannot disturb the timer. The upper bits of each written word must carry a key byte, and each register has its own key. If the key is wrong, nothing changes. A separate restart location clears the count. It has its own key, which sits in the top byte of the word.

The register port is a single-cycle write strobe with an address and a 32-bit data word. Reads are combinational, byte wide, and need no key.

Top module: `wdt_guard`

## Requirements
- R1: A write to offset 0x0 loads bits 7:0 into the counter when bits 15:8 of the data equal 0x5A. The counter reads back at offset 0x0.
- R2: A write to offset 0x4 updates the control byte when bits 15:8 equal 0xA5. The control byte reads back at offset 0x4 without a key. Its layout is: bit 7 enable, bit 6 mode, bit 5 reset kind, bit 4 always 0, bit 3 overflow flag, bits 2:0 divide select.
- R3: A write to offset 0x8 with 0x55 in bits 31:24 clears the counter and restarts the prescaler. A write there with any other top byte is ignored.
- R4: A write whose key byte is wrong leaves the counter and the control byte unchanged.
- R5: While bit 7 is set, the counter increases by one every 2^(5+S) clock cycles, where S is bits 2:0. The first increase comes exactly 2^(5+S) cycles after the write that set bit 7.
- R6: A keyed control write that clears bit 7 stops the counter. The counter then holds its value.
- R7: When the counter wraps from 0xFF to 0x00, bit 3 is set. It stays set until a keyed control write with bit 3 at 0 clears it. Writing 1 to bit 3 never sets it.
- R8: With bit 6 at 1, a wrap drives exactly one reset output high for one cycle, in the cycle after the wrapping edge. The output is por_req when bit 5 is 0 and man_req when bit 5 is 1.
- R9: With bit 6 at 0, a wrap raises neither reset output. irq then follows the overflow flag.
- R10: A keyed control write that changes bits 2:0 restarts the prescaler from zero.
- R11: After reset, the counter and the control byte read 0x00 and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data, including the key byte |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| por_req | output | 1 | One-cycle power-on reset request |
| man_req | output | 1 | One-cycle manual reset request |
| irq | output | 1 | Interval-mode interrupt, held while the flag is set |

## Verification
The properties assume that bus_wr is a clean synchronous strobe and that bus_addr and bus_wdata are settled while bus_wr is high. The bench drives all three on the falling clock edge and holds them for exactly one cycle, which keeps within that assumption. The properties also treat a single write cycle as a single command, so the bench never issues two commands in one cycle. The stopped-counter property applies only to cycles without a write, because a keyed write may legally reload the counter while it is stopped. The bench loads the counter to 0xFF before enabling it, so each wrap falls at a known cycle.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    localparam int BUS_W   = 32;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 4;
    localparam int SEL_W   = 3;
    localparam int LOG_MIN = 5;

    localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_KICK  = 4'h8;

    localparam logic [7:0] KEY_COUNT = 8'h5A;
    localparam logic [7:0] KEY_CTRL  = 8'hA5;
    localparam logic [7:0] KEY_KICK  = 8'h55;

    // Control byte bit positions (software-visible layout).
    localparam int B_EN   = 7;
    localparam int B_MODE = 6;
    localparam int B_KIND = 5;
    localparam int B_FLAG = 3;

    typedef struct packed {
        logic             en;
        logic             wd_mode;
        logic             manual;
        logic [SEL_W-1:0] sel;
    } wdt_cfg_t;

    typedef struct packed {
        logic load_count;
        logic load_ctrl;
        logic kick;
    } wdt_cmd_t;

    function automatic wdt_cfg_t cfg_from_byte(input logic [REG_W-1:0] b);
        wdt_cfg_t c;
        c.en      = b[B_EN];
        c.wd_mode = b[B_MODE];
        c.manual  = b[B_KIND];
        c.sel     = b[SEL_W-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_byte(input wdt_cfg_t c, input logic flag);
        logic [REG_W-1:0] b;
        b         = '0;
        b[B_EN]   = c.en;
        b[B_MODE] = c.wd_mode;
        b[B_KIND] = c.manual;
        b[B_FLAG] = flag;
        b[SEL_W-1:0] = c.sel;
        return b;
    endfunction

endpackage

// File: rtl/wdt_keygate.sv
module wdt_keygate
    import wdt_guard_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output wdt_cmd_t          cmd
);
    logic [7:0] low_key;
    logic [7:0] top_key;

    assign low_key = wdata[15:8];
    assign top_key = wdata[BUS_W-1 -: 8];

    always_comb begin
        cmd            = '0;
        cmd.load_count = wr && (addr == OFS_COUNT) && (low_key == KEY_COUNT);
        cmd.load_ctrl  = wr && (addr == OFS_CTRL)  && (low_key == KEY_CTRL);
        cmd.kick       = wr && (addr == OFS_KICK)  && (top_key == KEY_KICK);
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int LOG_LO = 5,
    parameter int SW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          restart,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    localparam int NSEL = 1 << SW;
    localparam int PW   = LOG_LO + NSEL - 1;

    logic [PW-1:0] div_q;
    logic [PW-1:0] lim_tab [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_limit
        assign lim_tab[g] = PW'((64'd1 << (LOG_LO + g)) - 64'd1);
    end

    assign tick = run && (div_q == lim_tab[sel]);

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PW'(1);
        end
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          clear,
    input  logic          tick,
    output logic [CW-1:0] count,
    output logic          wrap
);
    // A software write in the same cycle wins over a tick.
    assign wrap = tick && !load && !clear && (count == {CW{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (clear) begin
            count <= '0;
        end else if (tick) begin
            count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              por_req,
    output logic              man_req,
    output logic              irq
);
    wdt_cmd_t         cmd;
    wdt_cfg_t         cfg_q;
    wdt_cfg_t         cfg_new;
    logic             flag_q;
    logic             tick;
    logic             wrap;
    logic             presc_restart;
    logic [REG_W-1:0] cnt_q;
    logic             por_q;
    logic             man_q;

    wdt_keygate u_gate (
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    assign cfg_new = cfg_from_byte(bus_wdata[REG_W-1:0]);

    assign presc_restart = cmd.kick || cmd.load_count ||
                           (cmd.load_ctrl && (cfg_new.sel != cfg_q.sel));

    wdt_prescaler #(
        .LOG_LO (LOG_MIN),
        .SW     (SEL_W)
    ) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg_q.en),
        .restart (presc_restart),
        .sel     (cfg_q.sel),
        .tick    (tick)
    );

    wdt_counter #(
        .CW (REG_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.load_count),
        .load_val (bus_wdata[REG_W-1:0]),
        .clear    (cmd.kick),
        .tick     (tick),
        .count    (cnt_q),
        .wrap     (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            flag_q <= 1'b0;
            por_q  <= 1'b0;
            man_q  <= 1'b0;
        end else begin
            if (cmd.load_ctrl) begin
                cfg_q <= cfg_new;
            end
            if (wrap) begin
                flag_q <= 1'b1;
            end else if (cmd.load_ctrl && !bus_wdata[B_FLAG]) begin
                flag_q <= 1'b0;
            end
            por_q <= wrap && cfg_q.wd_mode && !cfg_q.manual;
            man_q <= wrap && cfg_q.wd_mode &&  cfg_q.manual;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_COUNT: bus_rdata = cnt_q;
            OFS_CTRL:  bus_rdata = ctrl_to_byte(cfg_q, flag_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign por_req = por_q;
    assign man_req = man_q;
    assign irq     = flag_q && !cfg_q.wd_mode;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_guard_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              por_req,
    input logic              man_req,
    input logic [REG_W-1:0]  cnt,
    input logic              run,
    input logic [5:0]        cfg_bits,
    input logic              flag
);
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_COUNT && bus_wdata[15:8] == KEY_COUNT)
        |=> cnt == $past(bus_wdata[REG_W-1:0])); // R1

    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_KICK && bus_wdata[31:24] == KEY_KICK)
        |=> cnt == '0); // R3

    AST_BADKEY_CTRL: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[15:8] != KEY_CTRL)
        |=> $stable(cfg_bits)); // R4

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && !bus_wr) |=> $stable(cnt)); // R6

    AST_RESET_PULSE: assert property (@(posedge clk) disable iff (rst)
        (por_req || man_req) |=> !(por_req || man_req)); // R8

    AST_ONE_RESET_KIND: assert property (@(posedge clk) disable iff (rst)
        !(por_req && man_req)); // R8

    AST_RESET_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (por_req || man_req) |-> flag); // R7
endmodule

bind wdt_guard wdt_guard_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .por_req   (por_req),
    .man_req   (man_req),
    .cnt       (cnt_q),
    .run       (cfg_q.en),
    .cfg_bits  (cfg_q),
    .flag      (flag_q)
);

// File: tb/wdt_guard_tb_top.sv
`timescale 1ns/1ps
module wdt_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        por_req, man_req, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wdt_guard dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .por_req   (por_req),
        .man_req   (man_req),
        .irq       (irq)
    );

    // {addr, wdata, expected counter, expected control byte}
    localparam int NV = 9;
    localparam logic [51:0] VEC [NV] = '{
        {4'h0, 32'h0000_5A37, 8'h37, 8'h00},
        {4'h0, 32'h0000_5B11, 8'h37, 8'h00},
        {4'h4, 32'h0000_A547, 8'h37, 8'h47},
        {4'h4, 32'h0000_A405, 8'h37, 8'h47},
        {4'h8, 32'h5500_0000, 8'h00, 8'h47},
        {4'h0, 32'h0000_5A80, 8'h80, 8'h47},
        {4'h8, 32'h5400_0000, 8'h80, 8'h47},
        {4'h4, 32'h0000_A530, 8'h80, 8'h20},
        {4'h4, 32'h0000_A508, 8'h80, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wctrl(input logic [7:0] b); wr(4'h4, {16'h0, 8'hA5, b}); endtask
    task automatic wcount(input logic [7:0] b); wr(4'h0, {16'h0, 8'h5A, b}); endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int first, por_n, man_n, irq_first;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(4'h0, v); check("R11 counter after reset", v, 8'h00);
        rd(4'h4, v); check("R11 control after reset", v, 8'h00);
        check("R11 outputs after reset", {por_req, man_req, irq}, 3'b000);

        // Table: R1/R2/R3/R4 keyed and unkeyed writes with the counter stopped.
        for (int r = 0; r < NV; r++) begin
            wr(VEC[r][51:48], VEC[r][47:16]);
            rd(4'h0, v); check($sformatf("R1/R3/R4 row %0d counter", r), v, VEC[r][15:8]);
            rd(4'h4, v); check($sformatf("R2/R4 row %0d control", r), v, VEC[r][7:0]);
        end
        rd(4'h8, v); check("R2 unmapped read", v, 8'h00);

        // R5: tick period with S=0
        wcount(8'h00); wctrl(8'h80);
        idle(31); rd(4'h0, v); check("R5 no step before 32 cycles", v, 8'h00);
        idle(1);  rd(4'h0, v); check("R5 step at 32 cycles", v, 8'h01);

        // R3: kick restarts counter and prescaler
        idle(70); rd(4'h0, v); check("R5 third step", v, 8'h03);
        wr(4'h8, 32'h5500_0000);
        rd(4'h0, v); check("R3 kick clears", v, 8'h00);
        idle(31); rd(4'h0, v); check("R3 prescaler restarted", v, 8'h00);
        idle(1);  rd(4'h0, v); check("R3 step 32 after kick", v, 8'h01);

        // R6: disable stops counting
        wctrl(8'h00); wcount(8'h10); wctrl(8'h80);
        idle(100); rd(4'h0, v); check("R6 running count", v, 8'h13);
        wctrl(8'h00);
        idle(200); rd(4'h0, v); check("R6 stopped count holds", v, 8'h13);

        // R5/R10: S=1 and restart on select change
        wcount(8'h00); wctrl(8'h80); idle(20);
        wctrl(8'h81);
        idle(63); rd(4'h0, v); check("R10 no step before 64 after select change", v, 8'h00);
        idle(1);  rd(4'h0, v); check("R10 R5 step at 64", v, 8'h01);
        wctrl(8'h00);

        // R8: watchdog mode, power-on kind
        wcount(8'hFF); wctrl(8'hC0);
        first = -1; por_n = 0; man_n = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (por_req) begin por_n++; if (first < 0) first = k; end
            if (man_req) man_n++;
        end
        check("R8 por cycle", first, 32);
        check("R8 por width", por_n, 1);
        check("R8 no manual", man_n, 0);
        check("R9 no irq in watchdog mode", irq, 1'b0);
        rd(4'h4, v); check("R7 flag set", v, 8'hC8);
        rd(4'h0, v); check("R7 wrapped to zero", v, 8'h00);
        wctrl(8'h00);

        // R8: manual kind; R7 flag write rules
        wcount(8'hFF); wctrl(8'hE0);
        first = -1; por_n = 0; man_n = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (man_req) begin man_n++; if (first < 0) first = k; end
            if (por_req) por_n++;
        end
        check("R8 manual cycle", first, 32);
        check("R8 manual width", man_n, 1);
        check("R8 no por", por_n, 0);
        wctrl(8'hE8); rd(4'h4, v); check("R7 writing one keeps flag", v, 8'hE8);
        wctrl(8'hE0); rd(4'h4, v); check("R7 writing zero clears flag", v, 8'hE0);
        wctrl(8'h08); rd(4'h4, v); check("R7 one cannot set flag", v, 8'h00);

        // R9: interval mode
        wcount(8'hFF); wctrl(8'h80);
        irq_first = -1; por_n = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (irq && irq_first < 0) irq_first = k;
            if (por_req || man_req) por_n++;
        end
        check("R9 irq at wrap", irq_first, 32);
        check("R9 no reset in interval mode", por_n, 0);
        check("R9 irq held", irq, 1'b1);
        rd(4'h4, v); check("R9 R7 flag in interval", v, 8'h88);
        wr(4'h4, 32'h0000_A400); check("R4 bad key leaves irq", irq, 1'b1);
        wctrl(8'h80); check("R9 irq drops with flag", irq, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule